// File: doc/BRIEF.md
# Carry-Chain One-Hot Bit Selector

This block selects one bit out of a data vector, where the choice is given by a select vector of the same width that is expected to carry exactly one set bit. It does not build the usual AND-OR tree. Each operand bit is formed as "data bit, or the inverse of its select bit". That is the implication select-implies-data. The operand word is then incremented by one. An increment carries out of its top bit only when every operand bit is one. Every unselected position is forced to one, so the final carry equals the chosen data bit. Synthesis can therefore place the selector on dedicated carry logic.

A parameter chooses a grouped variant. In that variant each chain position first resolves three adjacent data bits against their three select lines. A chain of length N/3 then serves N inputs; for example, four positions serve twelve inputs. The block also computes an AND-OR result for comparison and classifies the select vector as empty, valid or multi-hot. It provides an output gated so that it reads zero when no select bit is set. An optional input register stage, off by default, delays every output by one clock.

Top module: `onehot_carry_sel`

## Requirements
- R1: With exactly one select bit set at position k, `carry_out` equals `data[k]`, in both the flat and the grouped variant.
- R2: `ref_out` equals the OR over all positions of `data[i] AND sel[i]`.
- R3: When `sel` is all zero, `sel_zero` is 1, `carry_out` is 1 and `gated_out` is 0.
- R4: `sel_multi` is 1 exactly when two or more select bits are set. In the flat variant `carry_out` is then the AND of the data bits at the set positions.
- R5: `sel_ok` is 1 exactly when one select bit is set.
- R6: Whenever `sel_multi` is 0, `gated_out` equals `ref_out`.
- R7: In the grouped variant, chain position j covers data bits 3j, 3j+1 and 3j+2. Within one position, several set select bits combine by OR. Across positions, they combine by AND.
- R8: With the register stage enabled, every output reflects the `data` and `sel` captured at the previous rising edge of `clk`. Reset clears the captured values to zero, so the outputs then show the empty-select state of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional input register stage |
| rst_n | input | 1 | Active-low reset of the register stage |
| data | input | N | Data bits to choose from |
| sel | input | N | Select vector, one-hot when used correctly |
| carry_out | output | 1 | Carry out of the incremented implication word |
| gated_out | output | 1 | `carry_out` forced low when no select bit is set |
| ref_out | output | 1 | AND-OR selection result for comparison |
| sel_ok | output | 1 | Exactly one select bit is set |
| sel_zero | output | 1 | No select bit is set |
| sel_multi | output | 1 | Two or more select bits are set |

## Verification
On every clock, the assertions compare the carry result with the AND-OR result for any one-hot select. They also tie the three select flags to the population count of the select vector. Two further checks run every cycle: an empty select must give a high carry with a low gated output, and a multi-hot select with a high carry must also give a high AND-OR result. Some behaviours can only be shown by the bench's chosen patterns. These are the exact AND of the selected bits in the flat variant, the OR-within-group and AND-across-group behaviour of the grouped variant, the one-edge latency of the register stage, and its reset state.

// File: rtl/onehot_carry_sel.sv
module onehot_carry_sel #(
  parameter int N       = 12,
  parameter bit GROUPED = 1'b0,
  parameter bit PIPE    = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] data,
  input  logic [N-1:0] sel,
  output logic         carry_out,
  output logic         gated_out,
  output logic         ref_out,
  output logic         sel_ok,
  output logic         sel_zero,
  output logic         sel_multi
);
  localparam int M = GROUPED ? N / 3 : N;

  logic [N-1:0] d_q, s_q;
  logic [M-1:0] imp;
  logic [M:0]   sum;

  if (N < 1 || (GROUPED && (N % 3) != 0)) begin : g_bad_width
    $error("onehot_carry_sel: N must be >= 1, and a multiple of 3 when grouped");
  end

  if (PIPE) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        s_q <= '0;
      end else begin
        d_q <= data;
        s_q <= sel;
      end
    end
  end else begin : g_comb
    assign d_q = data;
    assign s_q = sel;
  end

  for (genvar j = 0; j < M; j++) begin : g_chain
    if (GROUPED) begin : g_tri
      assign imp[j] = (|(d_q[3*j +: 3] & s_q[3*j +: 3])) | ~(|s_q[3*j +: 3]);
    end else begin : g_one
      assign imp[j] = d_q[j] | ~s_q[j];
    end
  end

  assign sum       = {1'b0, imp} + (M+1)'(1);
  assign carry_out = sum[M];
  assign ref_out   = |(d_q & s_q);
  assign sel_zero  = ~(|s_q);
  assign sel_multi = |(s_q & (s_q - N'(1)));
  assign sel_ok    = ~sel_zero & ~sel_multi;
  assign gated_out = carry_out & ~sel_zero;
endmodule

module onehot_carry_sel_chk #(
  parameter int N    = 12,
  parameter bit PIPE = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] data,
  input logic [N-1:0] sel,
  input logic         carry_out,
  input logic         gated_out,
  input logic         ref_out,
  input logic         sel_ok,
  input logic         sel_zero,
  input logic         sel_multi
);
  logic [N-1:0] dc, sc;

  if (PIPE) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dc <= '0;
        sc <= '0;
      end else begin
        dc <= data;
        sc <= sel;
      end
    end
  end else begin : g_pass
    assign dc = data;
    assign sc = sel;
  end

  p_onehot_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sc) == 1) |-> (carry_out == ($countones(dc & sc) == 1)));
  p_ref_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_out == ($countones(dc & sc) != 0));
  p_zero_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sc) == 0) |-> (sel_zero && carry_out && !gated_out));
  p_multi_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_multi == ($countones(sc) > 1));
  p_multi_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_multi && carry_out) |-> ref_out);
  p_valid_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok == ($countones(sc) == 1));
  p_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_multi |-> (gated_out == ref_out));
endmodule

bind onehot_carry_sel onehot_carry_sel_chk #(.N(N), .PIPE(PIPE)) i_chk (
  .clk(clk), .rst_n(rst_n), .data(data), .sel(sel),
  .carry_out(carry_out), .gated_out(gated_out), .ref_out(ref_out),
  .sel_ok(sel_ok), .sel_zero(sel_zero), .sel_multi(sel_multi)
);

// File: tb/test_onehot_carry_sel.sv
`timescale 1ns/1ps
module test_onehot_carry_sel;
  localparam int N = 12;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] data = '0, sel = '0;
  logic f_c, f_g, f_r, f_ok, f_z, f_m;
  logic g_c, g_g, g_r, g_ok, g_z, g_m;
  logic p_c, p_g, p_r, p_ok, p_z, p_m;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  onehot_carry_sel #(.N(N)) i_onehot_carry_sel (
    .clk(clk), .rst_n(rst_n), .data(data), .sel(sel),
    .carry_out(f_c), .gated_out(f_g), .ref_out(f_r),
    .sel_ok(f_ok), .sel_zero(f_z), .sel_multi(f_m));
  onehot_carry_sel #(.N(N), .GROUPED(1'b1)) i_onehot_carry_sel_grp (
    .clk(clk), .rst_n(rst_n), .data(data), .sel(sel),
    .carry_out(g_c), .gated_out(g_g), .ref_out(g_r),
    .sel_ok(g_ok), .sel_zero(g_z), .sel_multi(g_m));
  onehot_carry_sel #(.N(N), .PIPE(1'b1)) i_onehot_carry_sel_pipe (
    .clk(clk), .rst_n(rst_n), .data(data), .sel(sel),
    .carry_out(p_c), .gated_out(p_g), .ref_out(p_r),
    .sel_ok(p_ok), .sel_zero(p_z), .sel_multi(p_m));

  // fields: data, sel, carry, gated, ok, zero, multi
  typedef struct packed {
    logic [N-1:0] d;
    logic [N-1:0] s;
    logic c, g, ok, z, m;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{12'h000, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{12'hFFF, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{12'h001, 12'h001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'hFFE, 12'h001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{12'h800, 12'h800, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'h7FF, 12'h800, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{12'h005, 12'h005, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{12'h001, 12'h005, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{12'h0F0, 12'h030, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{12'h400, 12'h440, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  function automatic logic exp_ref(logic [N-1:0] d, logic [N-1:0] s);
    logic r = 1'b0;
    for (int i = 0; i < N; i++) if (s[i] && d[i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic exp_grp(logic [N-1:0] d, logic [N-1:0] s);
    logic r = 1'b1;
    for (int g = 0; g < N/3; g++) begin
      logic any = 1'b0, val = 1'b0;
      for (int k = 0; k < 3; k++) begin
        if (s[3*g+k]) any = 1'b1;
        if (s[3*g+k] && d[3*g+k]) val = 1'b1;
      end
      if (any && !val) r = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(logic got, logic exp, string req, string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b (data=%h sel=%h)", req, what, got, exp, data, sel);
    end
  endtask

  task automatic apply(logic [N-1:0] d, logic [N-1:0] s);
    @(negedge clk);
    data = d;
    sel  = s;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(p_z, 1'b1, "R8", "pipe zero flag in reset");
    chk(p_g, 1'b0, "R8", "pipe gated in reset");
    chk(p_c, 1'b1, "R3", "pipe carry in reset");
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(VT[v].d, VT[v].s);
      chk(f_c,  VT[v].c,  "R4", "flat carry (table)");
      chk(f_g,  VT[v].g,  "R6", "flat gated (table)");
      chk(f_ok, VT[v].ok, "R5", "ok flag (table)");
      chk(f_z,  VT[v].z,  "R3", "zero flag (table)");
      chk(f_m,  VT[v].m,  "R4", "multi flag (table)");
      chk(f_r,  exp_ref(VT[v].d, VT[v].s), "R2", "ref (table)");
      chk(g_c,  exp_grp(VT[v].d, VT[v].s), "R7", "grouped carry (table)");
    end

    for (int i = 0; i < N; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [N-1:0] d = N'($urandom);
        d[i] = pol[0];
        apply(d, N'(1) << i);
        chk(f_c, pol[0], "R1", "flat one-hot carry");
        chk(g_c, pol[0], "R1", "grouped one-hot carry");
        chk(f_r, pol[0], "R2", "ref one-hot");
        chk(f_g, f_r, "R6", "gated vs ref");
        chk(f_ok, 1'b1, "R5", "ok one-hot");
      end
    end

    apply(12'h001, 12'h003);
    chk(g_c, 1'b1, "R7", "grouped OR within position");
    chk(f_c, 1'b0, "R4", "flat AND of selected");
    chk(g_m, 1'b1, "R4", "grouped multi flag");
    apply(12'h009, 12'h009);
    chk(g_c, 1'b1, "R7", "grouped AND across positions, both set");
    apply(12'h008, 12'h009);
    chk(g_c, 1'b0, "R7", "grouped AND across positions, one clear");
    apply(12'hFFF, 12'h000);
    chk(g_c, 1'b1, "R3", "grouped carry empty select");
    chk(g_g, 1'b0, "R3", "grouped gated empty select");

    @(posedge clk);
    apply(12'h010, 12'h010);
    chk(p_z, 1'b1, "R8", "pipe holds previous capture");
    chk(p_g, 1'b0, "R8", "pipe gated before edge");
    @(posedge clk); #1;
    chk(p_ok, 1'b1, "R8", "pipe ok after edge");
    chk(p_g, 1'b1, "R8", "pipe gated after edge");
    chk(p_c, 1'b1, "R8", "pipe carry after edge");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule